// File: doc/BRIEF.md
# Dual-Edge GPIO Interrupt Controller

This block watches a bank of general-purpose pins and turns their level changes into one interrupt request for a host processor. Every pin goes through a two-stage synchronizer before edge detection. A rising edge and a falling edge each have their own per-pin enable mask. Each polarity also has its own sticky status word. A status bit is set by an enabled edge and stays set until the host writes a one to that bit.

The same register port also holds a per-pin direction mask and an output data word, which drive the output-enable and output-data pins of the bank. It also returns the synchronized input levels. The host bus is a simple synchronous word-wide read/write port. Writes are taken on the clock edge and reads are combinational from the address. The two bytes of every register are exchanged between the bus and the register.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the direction, output data, both enable masks and both status words are zero, so `pin_oe` and `pin_out` are 0 and `irq` is low.
- R2: Register offsets are: direction 0, input level 1, output data 2, rise enable 3, fall enable 4, rise status 5, fall status 6; offset 7 reads zero. Bus bits [15:8] carry register bits [7:0] and bus bits [7:0] carry register bits [15:8], on both write and read. Register bit i belongs to pin i.
- R3: `pin_oe` equals the direction register and `pin_out` equals the output data register, from the clock edge after the write.
- R4: The input level register shows `pin_in` as it was two clock edges earlier.
- R5: A rising edge on a pin sets its rise status bit if the pin's rise enable bit is set at the edge where the change is detected. That is the third clock edge after `pin_in` changes.
- R6: A falling edge sets the pin's fall status bit under the same rule, using the fall enable mask.
- R7: An edge whose enable bit is clear sets no status bit.
- R8: A write to a status register clears exactly the bits written as one and leaves all other bits unchanged. A write to the input level register has no effect.
- R9: When an enabled edge and a clearing write hit the same status bit on the same clock edge, the bit ends up set.
- R10: `irq` is a register. It is high on the edge after any status bit whose enable is set becomes set, and low on the edge after no such bit remains.
- R11: A single level change sets its status bit once. A level that then stays steady does not set the bit again after it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write qualifier for the strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data, byte-swapped relative to the register |
| bus_rdata | output | 16 | Read data, byte-swapped relative to the register |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output data per pin |
| pin_oe | output | 16 | Output enable per pin (1 = drive) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an enabled edge and a clearing write landing on the same clock edge. The edge only reaches the status logic after the synchronizer and the edge register. The bench creates this case directly by issuing the clearing write exactly two bus cycles after the pin change. It then reads the status word back to confirm that the bit survived.

Random stimulus flips single pins and whole words, mixed with random writes to every offset. This covers clears and edges that overlap in many combinations. Each cycle is compared against a cycle model of the pipeline that the bench builds from the requirements.

// File: rtl/gei_pkg.sv
package gei_pkg;
  localparam int GEI_AW = 3;

  typedef enum logic [GEI_AW-1:0] {
    A_DIR  = 3'd0,
    A_DIN  = 3'd1,
    A_DOUT = 3'd2,
    A_REN  = 3'd3,
    A_FEN  = 3'd4,
    A_RST  = 3'd5,
    A_FST  = 3'd6,
    A_NONE = 3'd7
  } gei_addr_e;
endpackage

// File: rtl/gei_bswap.sv
module gei_bswap #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
  end
endmodule

// File: rtl/gei_sync2.sv
module gei_sync2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = async_in;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

  // R11: an edge pulse lasts one cycle only
  p_edge_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise) & rise) == '0) && (($past(fall) & fall) == '0));
  p_edge_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rise & fall) == '0);
endmodule

// File: rtl/gei_sticky.sv
module gei_sticky #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] en,
  input  logic [W-1:0] clr,
  output logic [W-1:0] st
);
  logic [W-1:0] st_q, st_d, set_v;
  logic         st_ce;

  always_comb begin
    set_v = ev & en;
    st_ce = (|clr) | (|set_v);
    st_d  = (st_q & ~clr) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (st_ce) begin
      st_q <= st_d;
    end
  end

  assign st = st_q;

  // R5/R6: an enabled edge always leaves its bit set
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev & en) & ~st) == '0));
  // R7: a disabled edge alone never sets a clear bit
  p_noset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~st & ~(ev & en)) & st) == '0));
  // R8: written-one bits without a concurrent set end up clear
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr & ~(ev & en)) & st) == '0));
  // R9: set wins over clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev & en & clr) & ~st) == '0));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gei_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [GEI_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     pin_in,
  output logic [DW-1:0]     pin_out,
  output logic [DW-1:0]     pin_oe,
  output logic              irq
);
  logic [DW-1:0] wr_val, rd_val;
  logic [DW-1:0] dir_q, dout_q, ren_q, fen_q;
  logic [DW-1:0] dir_d, dout_d, ren_d, fen_d;
  logic          we_dir, we_dout, we_ren, we_fen, we_rst, we_fst, wr_hit;
  logic [DW-1:0] lvl, rise_ev, fall_ev, rst_st, fst_st, clr_r, clr_f;
  logic          pend, irq_q, irq_d;

  gei_bswap #(.DW(DW)) u_wswap (.din(bus_wdata), .dout(wr_val));
  gei_bswap #(.DW(DW)) u_rswap (.din(rd_val),    .dout(bus_rdata));

  gei_sync2 #(.W(DW)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in),
    .lvl(lvl), .rise(rise_ev), .fall(fall_ev)
  );

  always_comb begin
    wr_hit  = bus_sel & bus_wr;
    we_dir  = wr_hit && (bus_addr == A_DIR);
    we_dout = wr_hit && (bus_addr == A_DOUT);
    we_ren  = wr_hit && (bus_addr == A_REN);
    we_fen  = wr_hit && (bus_addr == A_FEN);
    we_rst  = wr_hit && (bus_addr == A_RST);
    we_fst  = wr_hit && (bus_addr == A_FST);
    clr_r   = we_rst ? wr_val : '0;
    clr_f   = we_fst ? wr_val : '0;
    dir_d   = wr_val;
    dout_d  = wr_val;
    ren_d   = wr_val;
    fen_d   = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
    end else begin
      if (we_dir)  dir_q  <= dir_d;
      if (we_dout) dout_q <= dout_d;
      if (we_ren)  ren_q  <= ren_d;
      if (we_fen)  fen_q  <= fen_d;
    end
  end

  gei_sticky #(.W(DW)) u_rise_st (
    .clk(clk), .rst_n(rst_n), .ev(rise_ev), .en(ren_q), .clr(clr_r), .st(rst_st)
  );
  gei_sticky #(.W(DW)) u_fall_st (
    .clk(clk), .rst_n(rst_n), .ev(fall_ev), .en(fen_q), .clr(clr_f), .st(fst_st)
  );

  always_comb begin
    pend  = (|(rst_st & ren_q)) | (|(fst_st & fen_q));
    irq_d = pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_comb begin
    case (gei_addr_e'(bus_addr))
      A_DIR:   rd_val = dir_q;
      A_DIN:   rd_val = lvl;
      A_DOUT:  rd_val = dout_q;
      A_REN:   rd_val = ren_q;
      A_FEN:   rd_val = fen_q;
      A_RST:   rd_val = rst_st;
      A_FST:   rd_val = fst_st;
      default: rd_val = '0;
    endcase
  end

  assign pin_oe  = dir_q;
  assign pin_out = dout_q;
  assign irq     = irq_q;

  // R2: a direction write lands byte-exchanged on the output enables
  p_swap_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == A_DIR) |=>
      (pin_oe[7:0] == $past(bus_wdata[15:8]) && pin_oe[15:8] == $past(bus_wdata[7:0])));
  // R10: request follows pending status with one register stage
  p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> irq);
  p_irq_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> !irq);
  // R1: no request without any enable
  p_irq_noen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ren_q) == '0 && $past(fen_q) == '0) |-> !irq);
endmodule

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // cycle model state
  logic [15:0] m_s1, m_s2, m_prev, m_dir, m_dout, m_ren, m_fen, m_rst, m_fst;
  logic        m_irq;

  gpio_edge_irq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] sw(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  function automatic logic [15:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_dir;
      3'd1: return m_s2;
      3'd2: return m_dout;
      3'd3: return m_ren;
      3'd4: return m_fen;
      3'd5: return m_rst;
      3'd6: return m_fst;
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_prev = 0; m_dir = 0; m_dout = 0;
    m_ren = 0; m_fen = 0; m_rst = 0; m_fst = 0; m_irq = 0;
  endtask

  task automatic model_clock(input logic wr, input logic [2:0] a,
                             input logic [15:0] wd, input logic [15:0] pins);
    logic [15:0] v, evr, evf, cr, cf;
    logic        ni;
    v   = sw(wd);
    evr = m_s2 & ~m_prev;
    evf = ~m_s2 & m_prev;
    cr  = (wr && a == 3'd5) ? v : 16'h0;
    cf  = (wr && a == 3'd6) ? v : 16'h0;
    ni  = |((m_rst & m_ren) | (m_fst & m_fen));
    m_rst = (m_rst & ~cr) | (evr & m_ren);
    m_fst = (m_fst & ~cf) | (evf & m_fen);
    m_irq = ni;
    if (wr && a == 3'd0) m_dir  = v;
    if (wr && a == 3'd2) m_dout = v;
    if (wr && a == 3'd3) m_ren  = v;
    if (wr && a == 3'd4) m_fen  = v;
    m_prev = m_s2;
    m_s2   = m_s1;
    m_s1   = pins;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic step(input logic wr, input logic [2:0] a,
                      input logic [15:0] wd, input logic [15:0] pins);
    bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = wd; pin_in = pins;
    @(posedge clk);
    model_clock(wr, a, wd, pins);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    check("R3 pin_oe", pin_oe, m_dir);
    check("R3 pin_out", pin_out, m_dout);
    check("R10 irq", {15'h0, irq}, {15'h0, m_irq});
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1;
    check(tag, bus_rdata, sw(m_read(a)));
    bus_sel = 0;
  endtask

  task automatic rd_all();
    rd(3'd0, "R2 dir read");
    rd(3'd1, "R4 input level");
    rd(3'd2, "R2 dout read");
    rd(3'd3, "R2 rise enable read");
    rd(3'd4, "R2 fall enable read");
    rd(3'd5, "R5 rise status");
    rd(3'd6, "R6 fall status");
    rd(3'd7, "R2 unused offset");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pins;
    void'($urandom(32'h5eed_1234));
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; pin_in = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pin_oe", pin_oe, 16'h0);
    check("R1 pin_out", pin_out, 16'h0);
    check("R1 irq", {15'h0, irq}, 16'h0);
    rd_all();
    rst_n = 1;
    @(negedge clk);

    // R2/R3: byte swap on direction and data
    step(1, 3'd0, 16'h3412, 16'h0);
    check("R2 swapped oe", pin_oe, 16'h1234);
    rd(3'd0, "R2 dir readback");
    step(1, 3'd2, 16'hCDAB, 16'h0);
    check("R3 swapped out", pin_out, 16'hABCD);

    // R4: two-stage input level
    step(0, 0, 0, 16'h00F0);
    rd(3'd1, "R4 level after one edge");
    check("R4 not yet", bus_rdata, 16'h0);
    step(0, 0, 0, 16'h00F0);
    rd(3'd1, "R4 level after two edges");
    check("R4 visible", bus_rdata, sw(16'h00F0));
    pins = 16'h0;
    repeat (3) step(0, 0, 0, pins);

    // R5 then R10: rising edge on pin 0
    step(1, 3'd3, sw(16'h0001), pins);
    step(1, 3'd5, 16'hFFFF, pins);
    step(1, 3'd6, 16'hFFFF, pins);
    pins = 16'h0001;
    step(0, 0, 0, pins);
    step(0, 0, 0, pins);
    rd(3'd5, "R5 not yet");
    check("R5 pre-detect", bus_rdata, 16'h0);
    step(0, 0, 0, pins);
    rd(3'd5, "R5 set");
    check("R5 set value", bus_rdata, sw(16'h0001));
    check("R10 irq still low", {15'h0, irq}, 16'h0);
    step(0, 0, 0, pins);
    check("R10 irq high", {15'h0, irq}, 16'h1);

    // R7: falling edge with fall enable clear
    pins = 16'h0;
    repeat (4) step(0, 0, 0, pins);
    rd(3'd6, "R7 fall status");
    check("R7 no set", bus_rdata, 16'h0);

    // R9: clear lands on the same edge as a new rising edge
    pins = 16'h0001;
    step(0, 0, 0, pins);
    step(0, 0, 0, pins);
    step(1, 3'd5, sw(16'h0001), pins);
    rd(3'd5, "R9 read");
    check("R9 set wins", bus_rdata, sw(16'h0001));

    // R8/R10: clear and irq drop
    step(1, 3'd5, sw(16'h0001), pins);
    rd(3'd5, "R8 read");
    check("R8 cleared", bus_rdata, 16'h0);
    check("R10 irq lingers one cycle", {15'h0, irq}, 16'h1);
    step(0, 0, 0, pins);
    check("R10 irq low", {15'h0, irq}, 16'h0);

    // R11: steady level does not set again
    repeat (5) step(0, 0, 0, pins);
    rd(3'd5, "R11 read");
    check("R11 no re-set", bus_rdata, 16'h0);

    // R6/R8: two falling edges, partial clear
    step(1, 3'd4, sw(16'h0006), pins);
    pins = 16'h0006;
    repeat (4) step(0, 0, 0, pins);
    pins = 16'h0000;
    repeat (4) step(0, 0, 0, pins);
    rd(3'd6, "R6 read");
    check("R6 both set", bus_rdata, sw(16'h0006));
    step(1, 3'd6, sw(16'h0002), pins);
    rd(3'd6, "R8 read partial");
    check("R8 partial clear", bus_rdata, sw(16'h0004));
    step(1, 3'd6, 16'h0000, pins);
    rd(3'd6, "R8 zero write");
    check("R8 zero write keeps", bus_rdata, sw(16'h0004));
    step(1, 3'd1, 16'hFFFF, pins);
    rd(3'd1, "R8 input level write ignored");
    check("R8 level unchanged", bus_rdata, 16'h0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic        w;
      logic [2:0]  a;
      logic [15:0] d;
      int          r;
      r = $urandom_range(0, 99);
      if (r < 30)      pins = pins ^ (16'h1 << $urandom_range(0, 15));
      else if (r < 33) pins = 16'($urandom);
      w = ($urandom_range(0, 3) == 0);
      a = 3'($urandom_range(0, 7));
      d = 16'($urandom);
      step(w, a, d, pins);
      rd(3'($urandom_range(0, 7)), "R2 random read");
      if ((i % 64) == 0) begin
        rd(3'd5, "R5 random rise status");
        rd(3'd6, "R6 random fall status");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule